// File: doc/BRIEF.md
# Serial Character Receiver with Sync Hunt and Break Detect

This block turns a serial input line into parallel characters. It runs on a system clock and advances its serial timing only on cycles where a receive-clock enable is high. In asynchronous mode one bit lasts 16 or 64 enabled cycles. A falling edge on the line is treated as a possible start bit and is checked again half a bit later. The block then collects eight data bits, least significant first, an optional parity bit and one stop bit. In synchronous mode every enabled cycle carries one bit. Before it assembles any characters, the receiver must first align to a sync pattern of one or two bytes, or be started by an external signal.

Finished characters go into a holding register and raise a ready flag. A data read clears that flag. Overrun, framing and parity errors are sticky until a status read. One shared pin changes role with the mode. In asynchronous mode it is a break indicator output. In internal synchronous mode it is a sync-found output. In external synchronous mode it is an input that starts character assembly.

Top module: `serial_rx_core`

## Requirements
- R1: After reset, rx_ready, err_overrun, err_frame, err_parity and syn_out are all 0.
- R2: In asynchronous mode one bit lasts 16 enabled receive-clock cycles when baud_x64=0 and 64 when baud_x64=1. A frame is a low start bit, 8 data bits sent LSB first, an optional parity bit and a stop bit. The data bits appear on rx_data with rx_ready=1.
- R3: A low level on rxd is accepted as a start bit only if rxd is still low half a bit period later. A shorter low pulse produces no character.
- R4: A stop bit sampled low sets err_frame. The character is still delivered.
- R5: With par_en=1, a parity bit follows the data bits. With par_odd=0 the data bits plus the parity bit hold an even number of ones; with par_odd=1 they hold an odd number. A mismatch sets err_parity.
- R6: If a character completes while rx_ready is already 1 and no data read is made in that cycle, err_overrun is set and rx_data takes the new character.
- R7: A data read (rd_data=1 for one cycle) clears rx_ready. If a character completes in that same cycle, rx_ready stays 1 with the new character and err_overrun is not set.
- R8: A status read (rd_status=1 for one cycle) clears err_overrun, err_frame, err_parity and the internal sync-found output.
- R9: In asynchronous mode syn_out goes high when the stop bits of two consecutive characters are both sampled low. It returns low as soon as rxd is high.
- R10: In internal synchronous mode (mode_async=0, sync_ext=0, sync_dual=0), the receiver hunts bit by bit for sync_pat1. On a match syn_out goes high, and each following group of 8 bits is delivered as a character, LSB first.
- R11: With sync_dual=1, sync_pat1 must be followed directly by sync_pat2. If the 8 bits after sync_pat1 differ from sync_pat2, syn_out stays low and the hunt restarts.
- R12: In external synchronous mode (mode_async=0, sync_ext=1), syn_oe is 0. The first enabled cycle with syn_in high takes the rxd bit of that cycle as data bit 0, and assembly continues from there.
- R13: In synchronous mode no character is delivered before sync is reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxc_en | input | 1 | Receive-clock enable, one pulse per receive-clock period |
| rxd | input | 1 | Serial data input |
| mode_async | input | 1 | 1 selects asynchronous mode, 0 selects synchronous mode |
| baud_x64 | input | 1 | Asynchronous bit length: 0 gives 16 cycles, 1 gives 64 cycles |
| par_en | input | 1 | Enable the parity bit (asynchronous mode) |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| sync_ext | input | 1 | Synchronous mode is started externally through syn_in |
| sync_dual | input | 1 | Two sync bytes are required |
| sync_pat1 | input | 8 | First sync byte |
| sync_pat2 | input | 8 | Second sync byte |
| rd_data | input | 1 | Data read strobe |
| rd_status | input | 1 | Status read strobe |
| syn_in | input | 1 | Shared pin, input value |
| rx_data | output | 8 | Last received character |
| rx_ready | output | 1 | A character is waiting to be read |
| err_overrun | output | 1 | Sticky overrun flag |
| err_frame | output | 1 | Sticky framing error flag |
| err_parity | output | 1 | Sticky parity error flag |
| syn_out | output | 1 | Shared pin, output value (break or sync found) |
| syn_oe | output | 1 | Shared pin, output enable |

## Verification
A data read can fall in the same cycle in which the next character completes. In that cycle the clear of the ready flag and the loading of the new character compete. The bench provokes this in external synchronous mode, where the receive clock runs every cycle and the completion cycle can be computed exactly from the bit on which syn_in rose. It places the read strobe on that cycle. It then expects ready still high, the second character in the holding register and no overrun. A third character with no read then shows that the overrun path still works.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [2:0] {A_IDLE, A_START, A_DATA, A_PAR, A_STOP} async_st_e;
  typedef enum logic [1:0] {S_HUNT1, S_HUNT2, S_WAITX, S_ASM} sync_st_e;
endpackage

// File: rtl/serial_rx_async.sv
module serial_rx_async
  import serial_rx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int FAST_DIV = 16,
  parameter int SLOW_DIV = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              enable,
  input  logic              sel_slow,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              rxd_s,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              frame_bad,
  output logic              par_bad,
  output logic              brk
);
  localparam int CW = $clog2(SLOW_DIV);
  localparam int BW = $clog2(DATA_W);
  localparam logic [CW-1:0] FAST_LAST = CW'(FAST_DIV - 1);
  localparam logic [CW-1:0] SLOW_LAST = CW'(SLOW_DIV - 1);
  localparam logic [CW-1:0] FAST_HALF = CW'(FAST_DIV / 2 - 1);
  localparam logic [CW-1:0] SLOW_HALF = CW'(SLOW_DIV / 2 - 1);
  localparam logic [BW-1:0] LAST_BIT  = BW'(DATA_W - 1);

  async_st_e         st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              done_q, done_d, fbad_q, fbad_d, pbad_q, pbad_d;
  logic              low_q, low_d, brk_q, brk_d;
  logic [CW-1:0]     last, half;
  logic              bit_end;

  assign last    = sel_slow ? SLOW_LAST : FAST_LAST;
  assign half    = sel_slow ? SLOW_HALF : FAST_HALF;
  assign bit_end = (cnt_q == last);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    done_d = 1'b0;
    fbad_d = fbad_q;
    pbad_d = pbad_q;
    low_d  = low_q;
    brk_d  = brk_q;
    if (!enable) begin
      st_d  = A_IDLE;
      low_d = 1'b0;
      brk_d = 1'b0;
    end else if (tick) begin
      case (st_q)
        A_IDLE: if (!rxd_s) begin
          st_d  = A_START;
          cnt_d = '0;
        end
        A_START: if (cnt_q == half) begin
          cnt_d  = '0;
          bit_d  = '0;
          pbad_d = 1'b0;
          st_d   = rxd_s ? A_IDLE : A_DATA;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
        A_DATA: if (bit_end) begin
          cnt_d = '0;
          sh_d  = {rxd_s, sh_q[DATA_W-1:1]};
          if (bit_q == LAST_BIT) st_d = par_en ? A_PAR : A_STOP;
          else                   bit_d = bit_q + 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
        A_PAR: if (bit_end) begin
          cnt_d  = '0;
          pbad_d = ((^sh_q) ^ rxd_s) != par_odd;
          st_d   = A_STOP;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
        A_STOP: if (bit_end) begin
          cnt_d  = '0;
          done_d = 1'b1;
          fbad_d = !rxd_s;
          low_d  = !rxd_s;
          if (!rxd_s && low_q) brk_d = 1'b1;
          st_d   = A_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
        default: st_d = A_IDLE;
      endcase
    end
    if (brk_q && rxd_s) brk_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= A_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
      fbad_q <= 1'b0;
      pbad_q <= 1'b0;
      low_q  <= 1'b0;
      brk_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      done_q <= done_d;
      fbad_q <= fbad_d;
      pbad_q <= pbad_d;
      low_q  <= low_d;
      brk_q  <= brk_d;
    end
  end

  assign done      = done_q;
  assign data      = sh_q;
  assign frame_bad = fbad_q;
  assign par_bad   = pbad_q;
  assign brk       = brk_q;

  // R3
  start_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == A_DATA && $past(st_q) == A_START) |-> $past(!rxd_s));
  // R9
  brk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_q) |-> $past(!rxd_s && st_q == A_STOP));
endmodule

// File: rtl/serial_rx_sync.sv
module serial_rx_sync
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              enable,
  input  logic              ext,
  input  logic              dual,
  input  logic [DATA_W-1:0] pat1,
  input  logic [DATA_W-1:0] pat2,
  input  logic              rxd_s,
  input  logic              start_s,
  input  logic              clr_det,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              det
);
  localparam int BW = $clog2(DATA_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

  sync_st_e          st_q, st_d;
  logic [BW-1:0]     cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d, sh_nx;
  logic              done_q, done_d, det_q, det_d;

  assign sh_nx = {rxd_s, sh_q[DATA_W-1:1]};

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    done_d = 1'b0;
    det_d  = det_q;
    if (clr_det) det_d = 1'b0;
    if (!enable) begin
      st_d  = S_HUNT1;
      cnt_d = '0;
      det_d = 1'b0;
    end else begin
      case (st_q)
        S_HUNT1: if (ext) begin
          st_d  = S_WAITX;
          cnt_d = '0;
        end else if (tick) begin
          sh_d  = sh_nx;
          cnt_d = (cnt_q == LAST_BIT) ? cnt_q : cnt_q + 1'b1;
          if (cnt_q == LAST_BIT && sh_nx == pat1) begin
            cnt_d = '0;
            if (dual) begin
              st_d = S_HUNT2;
            end else begin
              st_d  = S_ASM;
              det_d = 1'b1;
            end
          end
        end
        S_HUNT2: if (tick) begin
          sh_d  = sh_nx;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST_BIT) begin
            cnt_d = '0;
            if (sh_nx == pat2) begin
              st_d  = S_ASM;
              det_d = 1'b1;
            end else begin
              st_d = S_HUNT1;
            end
          end
        end
        S_WAITX: if (tick && start_s) begin
          sh_d  = sh_nx;
          cnt_d = BW'(1);
          st_d  = S_ASM;
        end
        S_ASM: if (tick) begin
          sh_d = sh_nx;
          if (cnt_q == LAST_BIT) begin
            cnt_d  = '0;
            done_d = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: st_d = S_HUNT1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_HUNT1;
      cnt_q  <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
      det_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      done_q <= done_d;
      det_q  <= det_d;
    end
  end

  assign done = done_q;
  assign data = sh_q;
  assign det  = det_q;

  // R13
  asm_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(st_q == S_ASM));
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core #(
  parameter int DATA_W   = 8,
  parameter int FAST_DIV = 16,
  parameter int SLOW_DIV = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxc_en,
  input  logic              rxd,
  input  logic              mode_async,
  input  logic              baud_x64,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              sync_ext,
  input  logic              sync_dual,
  input  logic [DATA_W-1:0] sync_pat1,
  input  logic [DATA_W-1:0] sync_pat2,
  input  logic              rd_data,
  input  logic              rd_status,
  input  logic              syn_in,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              err_overrun,
  output logic              err_frame,
  output logic              err_parity,
  output logic              syn_out,
  output logic              syn_oe
);
  logic [1:0]        rxd_meta_q, start_meta_q;
  logic              rxd_s, start_s;
  logic              a_done, a_fbad, a_pbad, a_brk, s_done, s_det;
  logic [DATA_W-1:0] a_data, s_data;
  logic              char_vld;
  logic [DATA_W-1:0] char_val;
  logic              rdy_q, rdy_d, ovr_q, ovr_d, fe_q, fe_d, pe_q, pe_d;
  logic [DATA_W-1:0] dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_meta_q   <= 2'b11;
      start_meta_q <= 2'b00;
    end else begin
      rxd_meta_q   <= {rxd_meta_q[0], rxd};
      start_meta_q <= {start_meta_q[0], syn_in};
    end
  end
  assign rxd_s   = rxd_meta_q[1];
  assign start_s = start_meta_q[1];

  serial_rx_async #(.DATA_W(DATA_W), .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_async (
    .clk(clk), .rst_n(rst_n), .tick(rxc_en), .enable(mode_async), .sel_slow(baud_x64),
    .par_en(par_en), .par_odd(par_odd), .rxd_s(rxd_s), .done(a_done), .data(a_data),
    .frame_bad(a_fbad), .par_bad(a_pbad), .brk(a_brk));

  serial_rx_sync #(.DATA_W(DATA_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .tick(rxc_en), .enable(!mode_async), .ext(sync_ext),
    .dual(sync_dual), .pat1(sync_pat1), .pat2(sync_pat2), .rxd_s(rxd_s),
    .start_s(start_s), .clr_det(rd_status), .done(s_done), .data(s_data), .det(s_det));

  assign char_vld = mode_async ? a_done : s_done;
  assign char_val = mode_async ? a_data : s_data;

  always_comb begin
    rdy_d = rdy_q;
    ovr_d = ovr_q;
    fe_d  = fe_q;
    pe_d  = pe_q;
    if (rd_data) rdy_d = 1'b0;
    if (rd_status) begin
      ovr_d = 1'b0;
      fe_d  = 1'b0;
      pe_d  = 1'b0;
    end
    if (char_vld) begin
      rdy_d = 1'b1;
      if (rdy_q && !rd_data) ovr_d = 1'b1;
      if (mode_async && a_fbad) fe_d = 1'b1;
      if (mode_async && a_pbad) pe_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      ovr_q <= 1'b0;
      fe_q  <= 1'b0;
      pe_q  <= 1'b0;
    end else begin
      rdy_q <= rdy_d;
      ovr_q <= ovr_d;
      fe_q  <= fe_d;
      pe_q  <= pe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dat_q <= '0;
    else if (char_vld) dat_q <= char_val;
  end

  assign rx_data     = dat_q;
  assign rx_ready    = rdy_q;
  assign err_overrun = ovr_q;
  assign err_frame   = fe_q;
  assign err_parity  = pe_q;
  assign syn_oe      = mode_async || !sync_ext;
  assign syn_out     = mode_async ? a_brk : (s_det && !sync_ext);

  // R7
  ready_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> $past(char_vld));
  // R6
  overrun_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overrun) |-> $past(rx_ready && char_vld && !rd_data));
  // R8
  status_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && !char_vld) |=> (!err_frame && !err_parity && !err_overrun));
endmodule

// File: tb/serial_rx_core_bench.sv
module serial_rx_core_bench;
  logic       clk, rst_n, rxc_en, rxd, mode_async, baud_x64, par_en, par_odd;
  logic       sync_ext, sync_dual, rd_data, rd_status, syn_in;
  logic [7:0] sync_pat1, sync_pat2, rx_data;
  logic       rx_ready, err_overrun, err_frame, err_parity, syn_out, syn_oe;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         finished = 0;

  serial_rx_core u_serial_rx_core (
    .clk(clk), .rst_n(rst_n), .rxc_en(rxc_en), .rxd(rxd), .mode_async(mode_async),
    .baud_x64(baud_x64), .par_en(par_en), .par_odd(par_odd), .sync_ext(sync_ext),
    .sync_dual(sync_dual), .sync_pat1(sync_pat1), .sync_pat2(sync_pat2),
    .rd_data(rd_data), .rd_status(rd_status), .syn_in(syn_in), .rx_data(rx_data),
    .rx_ready(rx_ready), .err_overrun(err_overrun), .err_frame(err_frame),
    .err_parity(err_parity), .syn_out(syn_out), .syn_oe(syn_oe));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    rxd = 1'b1; rd_data = 1'b0; rd_status = 1'b0; syn_in = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
  endtask

  task automatic drive_bit(input logic v, input int n);
    @(negedge clk) rxd = v;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input bit with_par, input logic pv, input logic stopv);
    int f = baud_x64 ? 64 : 16;
    drive_bit(1'b0, f);
    for (int i = 0; i < 8; i++) drive_bit(b[i], f);
    if (with_par) drive_bit(pv, f);
    drive_bit(stopv, f);
    drive_bit(1'b1, 2 * f);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk) rxd = b[i];
    end
  endtask

  task automatic pulse_rd_data();
    @(negedge clk) rd_data = 1'b1;
    @(negedge clk) rd_data = 1'b0;
  endtask

  task automatic pulse_rd_status();
    @(negedge clk) rd_status = 1'b1;
    @(negedge clk) rd_status = 1'b0;
  endtask

  task automatic set_async(input bit slow, input bit pen);
    mode_async = 1'b1; baud_x64 = slow; par_en = pen; par_odd = 1'b0;
    sync_ext = 1'b0; sync_dual = 1'b0;
    do_reset();
  endtask

  task automatic t_reset();
    set_async(0, 0);
    chk("R1 rx_ready", rx_ready, 0);
    chk("R1 err_overrun", err_overrun, 0);
    chk("R1 err_frame", err_frame, 0);
    chk("R1 err_parity", err_parity, 0);
    chk("R1 syn_out", syn_out, 0);
  endtask

  task automatic t_async_basic();
    set_async(0, 0);
    send_frame(8'hA5, 0, 1'b0, 1'b1);
    chk("R2 x16 data", rx_data, 8'hA5);
    chk("R2 x16 ready", rx_ready, 1);
    chk("R4 no frame err", err_frame, 0);
    pulse_rd_data();
    chk("R7 read clears ready", rx_ready, 0);
    set_async(1, 0);
    send_frame(8'h3C, 0, 1'b0, 1'b1);
    chk("R2 x64 data", rx_data, 8'h3C);
    chk("R2 x64 ready", rx_ready, 1);
  endtask

  task automatic t_false_start();
    set_async(0, 0);
    drive_bit(1'b0, 4);
    drive_bit(1'b1, 16 * 12);
    chk("R3 glitch gives no char", rx_ready, 0);
  endtask

  task automatic t_frame();
    set_async(0, 0);
    send_frame(8'h5A, 0, 1'b0, 1'b0);
    chk("R4 frame err set", err_frame, 1);
    chk("R4 data still delivered", rx_data, 8'h5A);
    chk("R4 ready", rx_ready, 1);
    chk("R9 single low stop no break", syn_out, 0);
    pulse_rd_status();
    chk("R8 status clears frame err", err_frame, 0);
  endtask

  task automatic t_parity_overrun();
    set_async(0, 1);
    send_frame(8'h07, 1, ^8'h07, 1'b1);
    chk("R5 good parity", err_parity, 0);
    chk("R5 data", rx_data, 8'h07);
    send_frame(8'h0F, 1, ~(^8'h0F), 1'b1);
    chk("R5 bad parity flagged", err_parity, 1);
    chk("R6 overrun set", err_overrun, 1);
    chk("R6 new data kept", rx_data, 8'h0F);
    pulse_rd_status();
    chk("R8 status clears parity", err_parity, 0);
    chk("R8 status clears overrun", err_overrun, 0);
  endtask

  task automatic t_break();
    set_async(0, 0);
    drive_bit(1'b0, 3 * 11 * 16);
    chk("R9 break high", syn_out, 1);
    chk("R9 pin drives in async", syn_oe, 1);
    drive_bit(1'b1, 6);
    chk("R9 break clears on high", syn_out, 0);
  endtask

  task automatic t_sync_single();
    mode_async = 1'b0; sync_ext = 1'b0; sync_dual = 1'b0;
    sync_pat1 = 8'h16; sync_pat2 = 8'h3C;
    do_reset();
    send_byte(8'h00);
    send_byte(8'hA5);
    chk("R13 no char before sync", rx_ready, 0);
    chk("R10 no detect before pattern", syn_out, 0);
    send_byte(8'h16);
    send_byte(8'hA5);
    wait_cyc(4);
    chk("R10 sync found", syn_out, 1);
    chk("R10 char after sync", rx_data, 8'hA5);
    chk("R10 ready", rx_ready, 1);
    pulse_rd_status();
    chk("R8 status clears sync found", syn_out, 0);
  endtask

  task automatic t_sync_dual();
    mode_async = 1'b0; sync_ext = 1'b0; sync_dual = 1'b1;
    sync_pat1 = 8'h16; sync_pat2 = 8'h3C;
    do_reset();
    send_byte(8'h00);
    send_byte(8'h16);
    send_byte(8'h55);
    wait_cyc(4);
    chk("R11 mismatch keeps detect low", syn_out, 0);
    chk("R13 no char on mismatch", rx_ready, 0);
    send_byte(8'h00);
    send_byte(8'h16);
    send_byte(8'h3C);
    send_byte(8'h81);
    wait_cyc(4);
    chk("R11 pair found", syn_out, 1);
    chk("R11 char after pair", rx_data, 8'h81);
    chk("R11 ready", rx_ready, 1);
  endtask

  task automatic t_sync_ext();
    logic [23:0] stream;
    mode_async = 1'b0; sync_ext = 1'b1; sync_dual = 1'b0;
    do_reset();
    stream = {8'h96, 8'h5A, 8'hC3};
    chk("R12 pin is input", syn_oe, 0);
    wait_cyc(20);
    chk("R12 idle before start", rx_ready, 0);
    for (int i = 0; i < 28; i++) begin
      @(negedge clk);
      if (i == 11) begin
        chk("R12 first char", rx_data, 8'hC3);
        chk("R12 first ready", rx_ready, 1);
      end
      if (i == 19) begin
        chk("R7 same-cycle read keeps ready", rx_ready, 1);
        chk("R7 same-cycle read no overrun", err_overrun, 0);
        chk("R7 second char", rx_data, 8'h5A);
      end
      if (i == 27) begin
        chk("R6 sync overrun", err_overrun, 1);
        chk("R6 third char", rx_data, 8'h96);
      end
      rxd = (i < 24) ? stream[i] : 1'b1;
      if (i == 0) syn_in = 1'b1;
      rd_data = (i == 18);
    end
  endtask

  initial begin
    rst_n = 1'b0; rxc_en = 1'b1; rxd = 1'b1; mode_async = 1'b1; baud_x64 = 1'b0;
    par_en = 1'b0; par_odd = 1'b0; sync_ext = 1'b0; sync_dual = 1'b0;
    sync_pat1 = 8'h16; sync_pat2 = 8'h3C; rd_data = 1'b0; rd_status = 1'b0; syn_in = 1'b0;
    t_reset();
    t_async_basic();
    t_false_start();
    t_frame();
    t_parity_overrun();
    t_break();
    t_sync_single();
    t_sync_dual();
    t_sync_ext();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(10 * 150000);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule